// File: doc/BRIEF.md
# Block-Buffered Host Data Port

This block is a byte-wide staging buffer that sits between a processor bus and a storage-bus DMA engine. A single buffer (128 bytes by default) changes its role with a direction bit. In the write direction the host fills it one byte per data-port access and the DMA engine drains it. In the read direction the DMA engine fills it and the host drains it. Two flags hand each block from one side to the other. The buffer-not-ready flag tells the host that its side of the current block is used up. The controller-busy flag records that the host has handed over a full block that the engine has not yet consumed.

The host reaches a small register window through a register strobe and a two-bit offset. Offset 0 is control on write and status on read. Offset 1 is an 8-bit block counter. Offsets 2 and 3 read as all-ones. A separate strobe selects the data port. The DMA engine steps through the buffer with its own pointer. It sees the buffer byte at that pointer, both pointers, the handshake flags, the direction and the remaining block count. Each completed block decrements the counter, and when the counter reaches zero the counter-loaded flag is cleared.

Top module: `block_buffer_port`

## Requirements
- R1: After reset: buf_not_ready is 1, host_ptr is 128, dma_ptr is 0, direction is host-write (dir_to_host 0), ctrl_busy is 0, cnt_loaded is 0, block_count is 0, and every buffer byte is 0.
- R2: A data-port write (host_dsel=1, host_wr=1) stores host_wdata at host_ptr and increments host_ptr, but only when the direction is host-write and host_ptr is below 128. Otherwise it changes nothing.
- R3: The host write that brings host_ptr to 128 sets both buf_not_ready and ctrl_busy. Status bit 7 reads 1 only while ctrl_busy is 0.
- R4: A data-port read (host_dsel=1, host_wr=0) returns the byte at host_ptr and increments host_ptr, but only when the direction is host-read and host_ptr is below 128. Reaching 128 sets buf_not_ready. In any other state the read returns 0xFF and changes nothing.
- R5: buf_not_ready is 1 exactly when host_ptr equals 128. When a control write turns the direction from host-write to host-read, host_ptr becomes 128. When it turns the direction from host-read to host-write, host_ptr becomes 0. A control write that keeps the direction leaves host_ptr unchanged.
- R6: A control write (offset 0) stores host_wdata bits 6..3; bit 6 is the direction (1 = host-read). A status read at offset 0 returns {~ctrl_busy, stored bits 6..3, buf_not_ready, 2'b00}.
- R7: A counter write (offset 1) loads block_count and sets cnt_loaded. In the host-read direction it rearms host_ptr to 128; in the host-write direction it rearms host_ptr to 0. A read at offset 1 returns block_count.
- R8: Reads at offsets 2 and 3 return 0xFF, and writes to them change no output. When no read strobe is active, host_rdata is 0xFF.
- R9: A dma_step is accepted only while buf_not_ready and cnt_loaded are both 1. An accepted step advances dma_ptr, and in the host-read direction it first stores dma_wdata at dma_ptr. dma_rdata always shows the byte at dma_ptr.
- R10: The accepted step at dma_ptr 127 completes a block: dma_ptr and host_ptr go to 0, buf_not_ready and ctrl_busy clear, and block_count decrements modulo 256. If the new count is 0, cnt_loaded clears.
- R11: A control or counter write in the same cycle as a completing DMA step takes precedence for host_ptr, buf_not_ready and block_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Register window strobe (ignored while host_dsel is 1) |
| host_dsel | input | 1 | Data port strobe |
| host_wr | input | 1 | 1 = write access, 0 = read access |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| dma_step | input | 1 | DMA engine transfers one byte |
| dma_wdata | input | 8 | Byte from the storage bus (host-read direction) |
| dma_rdata | output | 8 | Buffer byte at dma_ptr |
| dma_ptr | output | 7 | DMA side buffer index |
| host_ptr | output | 8 | Host side index, 0..128 |
| buf_not_ready | output | 1 | Host side of the block is exhausted |
| ctrl_busy | output | 1 | Host handed a full block to the engine |
| dir_to_host | output | 1 | 1 = host-read direction |
| cnt_loaded | output | 1 | Block counter holds a live count |
| block_count | output | 8 | Remaining blocks |

## Verification
Directed passes move a full block each way. In the write direction the host fills the buffer and the engine drains it. In the read direction the engine fills it and the host drains it. These passes separate correct pointer wrap and flag hand-over from off-by-one errors at index 127/128. Overruns past the end, direction flips in both senses and counter loads in each direction show whether rearming picks the correct side. A counter write placed on the exact completing DMA step checks the precedence rule. A long random interleaving of data accesses, register writes and DMA steps is then compared each cycle against a behavioural model. This exposes gating faults that occur only when steps arrive while the host still owns the buffer.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
   localparam logic [1:0] OFS_CTRL  = 2'd0;
   localparam logic [1:0] OFS_COUNT = 2'd1;
   localparam int         DIR_POS   = 6;
   localparam int         CTL_HI    = 6;
   localparam int         CTL_LO    = 3;
   localparam int         CTL_W     = CTL_HI - CTL_LO + 1;
   localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/hdp_store.sv
module hdp_store #(
   parameter int DEPTH          = 128,
   parameter int DW             = 8,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW            = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [DW-1:0] rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [DW-1:0] rdata_b
);
   logic [DEPTH*DW-1:0] flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [DW-1:0] q;
      logic          hit;
      assign hit = we && (waddr == AW'(g));
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wdata;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) q <= wdata;
         end
      end
      assign flat[g*DW +: DW] = q;
   end

   assign rdata_a = flat[raddr_a*DW +: DW];
   assign rdata_b = flat[raddr_b*DW +: DW];
endmodule

// File: rtl/hdp_seq.sv
module hdp_seq
   import hdp_pkg::*;
#(
   parameter int DEPTH = 128,
   parameter int CNT_W = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [7:0]       wdata,
   input  logic             data_wr,
   input  logic             data_rd,
   input  logic             dma_step,
   input  logic [7:0]       dma_wdata,
   output logic [PW-1:0]    hptr,
   output logic [AW-1:0]    dptr,
   output logic             nrdy,
   output logic             busy,
   output logic             dir,
   output logic [CTL_W-1:0] ctl,
   output logic             loaded,
   output logic [CNT_W-1:0] count,
   output logic             mem_we,
   output logic [AW-1:0]    mem_waddr,
   output logic [7:0]       mem_wdata
);
   localparam logic [PW-1:0] FULL   = PW'(DEPTH);
   localparam logic [PW-1:0] LAST_H = PW'(DEPTH - 1);
   localparam logic [AW-1:0] LAST_D = AW'(DEPTH - 1);

   logic             host_wacc, host_racc, dma_acc, dma_last;
   logic             ctl_wr, cnt_wr, new_dir;
   logic [CNT_W-1:0] cnt_dec;

   assign dir       = ctl[DIR_POS-CTL_LO];
   assign host_wacc = data_wr && !dir && (hptr < FULL);
   assign host_racc = data_rd &&  dir && (hptr < FULL);
   assign dma_acc   = dma_step && nrdy && loaded;
   assign dma_last  = dma_acc && (dptr == LAST_D);
   assign cnt_dec   = count - CNT_W'(1);
   assign ctl_wr    = reg_wr && (reg_addr == OFS_CTRL);
   assign cnt_wr    = reg_wr && (reg_addr == OFS_COUNT);
   assign new_dir   = wdata[DIR_POS];

   // one write port, host and engine never own the buffer together
   assign mem_we    = host_wacc || (dma_acc && dir);
   assign mem_waddr = host_wacc ? hptr[AW-1:0] : dptr;
   assign mem_wdata = host_wacc ? wdata : dma_wdata;

   // later assignments deliberately override earlier ones (register writes last)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hptr   <= FULL;
         dptr   <= '0;
         nrdy   <= 1'b1;
         busy   <= 1'b0;
         ctl    <= '0;
         loaded <= 1'b0;
         count  <= '0;
      end else begin
         if (dma_acc) begin
            if (dma_last) begin
               dptr  <= '0;
               hptr  <= '0;
               nrdy  <= 1'b0;
               busy  <= 1'b0;
               count <= cnt_dec;
               if (cnt_dec == '0) loaded <= 1'b0;
            end else begin
               dptr <= dptr + AW'(1);
            end
         end
         if (host_wacc || host_racc) begin
            hptr <= hptr + PW'(1);
            if (hptr == LAST_H) begin
               nrdy <= 1'b1;
               if (host_wacc) busy <= 1'b1;
            end
         end
         if (ctl_wr) begin
            ctl <= wdata[CTL_HI:CTL_LO];
            if (new_dir && !dir) begin
               hptr <= FULL;
               nrdy <= 1'b1;
            end else if (!new_dir && dir) begin
               hptr <= '0;
               nrdy <= 1'b0;
            end
         end
         if (cnt_wr) begin
            count  <= wdata[CNT_W-1:0];
            loaded <= 1'b1;
            hptr   <= dir ? FULL : '0;
            nrdy   <= dir;
         end
      end
   end

   // R5
   nrdy_tracks_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nrdy == (hptr == FULL));

   // R2
   ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hptr <= FULL);

   // R3
   busy_with_nrdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> nrdy);

   // R9
   dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_step && !(nrdy && loaded)) |=> $stable(dptr));

   // R10
   last_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(loaded) |-> ($past(count) == CNT_W'(1)) && (count == '0));

   // R4
   read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_racc && !reg_wr) |=> (hptr == $past(hptr) + PW'(1)));
endmodule

// File: rtl/hdp_rdmux.sv
module hdp_rdmux
   import hdp_pkg::*;
#(
   parameter int DEPTH = 128,
   parameter int CNT_W = 8,
   localparam int PW   = $clog2(DEPTH) + 1
) (
   input  logic             data_rd,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic             dir,
   input  logic [PW-1:0]    hptr,
   input  logic [7:0]       buf_byte,
   input  logic             busy,
   input  logic [CTL_W-1:0] ctl,
   input  logic             nrdy,
   input  logic [CNT_W-1:0] count,
   output logic [7:0]       rdata
);
   localparam logic [PW-1:0] FULL = PW'(DEPTH);

   always_comb begin
      rdata = IDLE_BYTE;
      if (data_rd) begin
         if (dir && (hptr < FULL)) rdata = buf_byte;
      end else if (reg_rd) begin
         case (reg_addr)
            OFS_CTRL:  rdata = {~busy, ctl, nrdy, 2'b00};
            OFS_COUNT: rdata = 8'(count);
            default:   rdata = IDLE_BYTE;
         endcase
      end
   end
endmodule

// File: rtl/block_buffer_port.sv
module block_buffer_port
   import hdp_pkg::*;
#(
   parameter int DEPTH          = 128,
   parameter int CNT_W          = 8,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW            = $clog2(DEPTH),
   localparam int PW            = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_sel,
   input  logic             host_dsel,
   input  logic             host_wr,
   input  logic [1:0]       host_addr,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata,
   input  logic             dma_step,
   input  logic [7:0]       dma_wdata,
   output logic [7:0]       dma_rdata,
   output logic [AW-1:0]    dma_ptr,
   output logic [PW-1:0]    host_ptr,
   output logic             buf_not_ready,
   output logic             ctrl_busy,
   output logic             dir_to_host,
   output logic             cnt_loaded,
   output logic [CNT_W-1:0] block_count
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("CNT_W must lie in 1..8");
   end

   logic             reg_wr, reg_rd, data_wr, data_rd;
   logic             mem_we;
   logic [AW-1:0]    mem_waddr;
   logic [7:0]       mem_wdata, host_byte;
   logic [CTL_W-1:0] ctl;

   assign reg_wr  = host_sel && !host_dsel && host_wr;
   assign reg_rd  = host_sel && !host_dsel && !host_wr;
   assign data_wr = host_dsel && host_wr;
   assign data_rd = host_dsel && !host_wr;

   hdp_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_seq (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(host_addr), .wdata(host_wdata),
      .data_wr(data_wr), .data_rd(data_rd),
      .dma_step(dma_step), .dma_wdata(dma_wdata),
      .hptr(host_ptr), .dptr(dma_ptr), .nrdy(buf_not_ready), .busy(ctrl_busy),
      .dir(dir_to_host), .ctl(ctl), .loaded(cnt_loaded), .count(block_count),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
   );

   hdp_store #(.DEPTH(DEPTH), .DW(8), .CLEAR_ON_RESET(CLEAR_ON_RESET)) i_store (
      .clk(clk), .rst_n(rst_n),
      .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr_a(host_ptr[AW-1:0]), .rdata_a(host_byte),
      .raddr_b(dma_ptr), .rdata_b(dma_rdata)
   );

   hdp_rdmux #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_rdmux (
      .data_rd(data_rd), .reg_rd(reg_rd), .reg_addr(host_addr),
      .dir(dir_to_host), .hptr(host_ptr), .buf_byte(host_byte),
      .busy(ctrl_busy), .ctl(ctl), .nrdy(buf_not_ready), .count(block_count),
      .rdata(host_rdata)
   );

   // R8
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_sel && !host_dsel) |-> (host_rdata == IDLE_BYTE));
endmodule

// File: tb/test_block_buffer_port.sv
module test_block_buffer_port;
   localparam int D = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel = 0, host_dsel = 0, host_wr = 0, dma_step = 0;
   logic [1:0] host_addr = 0;
   logic [7:0] host_wdata = 0, dma_wdata = 0;
   logic [7:0] host_rdata, dma_rdata, block_count, host_ptr;
   logic [6:0] dma_ptr;
   logic       buf_not_ready, ctrl_busy, dir_to_host, cnt_loaded;

   always #10 clk = ~clk;

   block_buffer_port i_block_buffer_port (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_dsel(host_dsel),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .dma_step(dma_step), .dma_wdata(dma_wdata),
      .dma_rdata(dma_rdata), .dma_ptr(dma_ptr), .host_ptr(host_ptr),
      .buf_not_ready(buf_not_ready), .ctrl_busy(ctrl_busy),
      .dir_to_host(dir_to_host), .cnt_loaded(cnt_loaded), .block_count(block_count)
   );

   int compared = 0, mismatched = 0;
   string cur_req = "R1";
   bit finished = 0;

   // behavioural reference
   int m_h = D, m_d = 0, m_nr = 1, m_busy = 0, m_ld = 0, m_cnt = 0, m_ctl = 0;
   logic [7:0] m_mem [D];

   initial foreach (m_mem[i]) m_mem[i] = 8'h00;

   function automatic int m_dir();
      return (m_ctl >> 3) & 1;
   endfunction

   function automatic int exp_rdata();
      if (host_dsel && !host_wr)
         return (m_dir() == 1 && m_h < D) ? int'(m_mem[m_h]) : 255;
      if (host_sel && !host_wr) begin
         if (host_addr == 0) return ((m_busy ? 0 : 128) | (m_ctl << 3) | (m_nr << 2));
         if (host_addr == 1) return m_cnt;
         return 255;
      end
      return 255;
   endfunction

   task automatic chk(string what, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("host_rdata", int'(host_rdata), exp_rdata());
      chk("dma_rdata", int'(dma_rdata), int'(m_mem[m_d]));
      chk("host_ptr", int'(host_ptr), m_h);
      chk("dma_ptr", int'(dma_ptr), m_d);
      chk("not_ready", int'(buf_not_ready), m_nr);
      chk("busy", int'(ctrl_busy), m_busy);
      chk("dir", int'(dir_to_host), m_dir());
      chk("loaded", int'(cnt_loaded), m_ld);
      chk("count", int'(block_count), m_cnt);
   endtask

   task automatic model_update();
      int o_h, o_dir, o_d, ndir;
      if (!rst_n) begin
         m_h = D; m_d = 0; m_nr = 1; m_busy = 0; m_ld = 0; m_cnt = 0; m_ctl = 0;
         foreach (m_mem[i]) m_mem[i] = 8'h00;
         return;
      end
      o_h = m_h; o_dir = m_dir(); o_d = m_d;
      if (dma_step && m_nr == 1 && m_ld == 1) begin
         if (o_dir == 1) m_mem[o_d] = dma_wdata;
         if (o_d == D - 1) begin
            m_d = 0; m_h = 0; m_nr = 0; m_busy = 0;
            m_cnt = (m_cnt + 255) % 256;
            if (m_cnt == 0) m_ld = 0;
         end else m_d = o_d + 1;
      end
      if (host_dsel && host_wr && o_dir == 0 && o_h < D) begin
         m_mem[o_h] = host_wdata;
         m_h = o_h + 1;
         if (m_h == D) begin m_nr = 1; m_busy = 1; end
      end
      if (host_dsel && !host_wr && o_dir == 1 && o_h < D) begin
         m_h = o_h + 1;
         if (m_h == D) m_nr = 1;
      end
      if (host_sel && !host_dsel && host_wr) begin
         if (host_addr == 0) begin
            ndir = int'(host_wdata[6]);
            if (ndir == 1 && o_dir == 0) begin m_h = D; m_nr = 1; end
            else if (ndir == 0 && o_dir == 1) begin m_h = 0; m_nr = 0; end
            m_ctl = int'(host_wdata[6:3]);
         end else if (host_addr == 1) begin
            m_cnt = int'(host_wdata); m_ld = 1;
            if (o_dir == 1) begin m_h = D; m_nr = 1; end
            else begin m_h = 0; m_nr = 0; end
         end
      end
   endtask

   task automatic tick();
      #2;
      compare_all();
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic drive(logic s, logic ds, logic w, logic [1:0] a, logic [7:0] wd,
                        logic st, logic [7:0] dw);
      host_sel = s; host_dsel = ds; host_wr = w; host_addr = a;
      host_wdata = wd; dma_step = st; dma_wdata = dw;
   endtask

   task automatic idle();
      drive(0, 0, 0, 2'd0, 8'h00, 0, 8'h00);
   endtask

   task automatic reg_write(logic [1:0] a, logic [7:0] v);
      drive(1, 0, 1, a, v, 0, 8'h00); tick(); idle();
   endtask

   task automatic reg_read(logic [1:0] a);
      drive(1, 0, 0, a, 8'h00, 0, 8'h00); tick(); idle();
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      cur_req = "R1";
      repeat (3) tick();
      rst_n = 1'b1;
      tick(); tick();

      cur_req = "R8";
      reg_read(2'd2); reg_read(2'd3);
      reg_write(2'd2, 8'h55); reg_write(2'd3, 8'hAA);
      reg_read(2'd0); tick();

      cur_req = "R6";
      reg_write(2'd0, 8'h3F);
      reg_read(2'd0);
      reg_write(2'd0, 8'h87);
      reg_read(2'd0);
      reg_write(2'd0, 8'h00);

      cur_req = "R7";
      reg_write(2'd1, 8'd2);
      reg_read(2'd1);

      cur_req = "R2";
      for (int i = 0; i < 5; i++) begin
         drive(0, 1, 1, 2'd0, 8'(i * 3 + 1), 0, 8'h00); tick();
      end
      cur_req = "R9";
      drive(0, 0, 0, 2'd0, 8'h00, 1, 8'hEE); tick();
      cur_req = "R2";
      for (int i = 5; i < D; i++) begin
         drive(0, 1, 1, 2'd0, 8'(i * 3 + 1), 0, 8'h00); tick();
      end
      cur_req = "R3";
      drive(0, 1, 1, 2'd0, 8'hC3, 0, 8'h00); tick();
      reg_read(2'd0);

      cur_req = "R9";
      for (int i = 0; i < D - 1; i++) begin
         drive(0, 0, 0, 2'd0, 8'h00, 1, 8'h00); tick();
      end
      cur_req = "R11";
      drive(1, 0, 1, 2'd1, 8'd3, 1, 8'h00); tick();
      idle(); tick();
      reg_read(2'd1);

      cur_req = "R5";
      reg_write(2'd0, 8'h40);
      reg_write(2'd0, 8'h48);
      cur_req = "R4";
      drive(0, 1, 0, 2'd0, 8'h00, 0, 8'h00); tick();
      cur_req = "R7";
      reg_write(2'd1, 8'd1);

      cur_req = "R10";
      for (int i = 0; i < D; i++) begin
         drive(0, 0, 0, 2'd0, 8'h00, 1, 8'(i ^ 8'h5A)); tick();
      end
      idle(); tick();
      cur_req = "R4";
      for (int i = 0; i <= D; i++) begin
         drive(0, 1, 0, 2'd0, 8'h00, 0, 8'h00); tick();
      end
      cur_req = "R9";
      drive(0, 0, 0, 2'd0, 8'h00, 1, 8'h11); tick();
      cur_req = "R5";
      reg_write(2'd0, 8'h00);
      reg_write(2'd0, 8'h08);
      reg_write(2'd0, 8'h40);
      cur_req = "R7";
      reg_write(2'd1, 8'd0);

      cur_req = "R11";
      for (int n = 0; n < 6000; n++) begin
         int r = $urandom_range(0, 99);
         logic [7:0] v = 8'($urandom);
         logic st = ($urandom_range(0, 1) == 1);
         if (r < 45)      drive(0, 1, v[0], 2'd0, v, st, 8'($urandom));
         else if (r < 55) drive(1, 0, 0, 2'($urandom), v, st, 8'($urandom));
         else if (r < 57) drive(1, 0, 1, 2'($urandom), v, st, 8'($urandom));
         else             drive(0, 0, 0, 2'd0, v, 1, 8'($urandom));
         tick();
      end
      idle(); tick();

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule